// File: doc/BRIEF.md
# Memory-Mapped Console I/O Controller

This block sits on a 16-bit processor bus and exposes a character keyboard and a character display as four word registers in a small address window. A processor polls the two status words and moves characters through the two data words using ordinary loads and stores. On a device read the block supplies the register contents in place of the memory data. On a display write it hands the low byte of the bus data to the display.

Bus accesses complete in a single cycle and are qualified by a valid strobe. Read data is combinational. It is the memory word for any address outside the window, and the selected register for an address inside it. Each side is gated by its ready flag. A key that arrives while an earlier character is still unread is dropped. A display write that arrives while the display is still busy is dropped.

Top module: `console_io_ctrl`

## Requirements
- R1: After reset the keyboard ready flag and keyboard data are zero, the display ready flag is one, `disp_valid` is low and `disp_char` is zero.
- R2: With `bus_valid` high and `bus_we` low, addresses 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status) and 0xFE06 (display data) raise `dev_sel` and return register contents. Any other address, or `bus_valid` low, leaves `dev_sel` low and passes `mem_rdata` to `bus_rdata`.
- R3: A `key_strobe` while the keyboard flag is zero stores `key_char`. The keyboard data word then reads {8'h00, char} and the keyboard status word reads 16'h8000, with the flag in bit 15.
- R4: A `key_strobe` while the keyboard flag is one is ignored: the stored character and the flag are unchanged.
- R5: A read of the keyboard data word clears the keyboard flag so that the next key is accepted. Reads of the keyboard status word leave the flag as it is.
- R6: The display status word reads {ready flag, 15'b0}.
- R7: A write to the display data word while the display flag is one clears the flag. In the next cycle `disp_valid` is high for exactly one cycle, with `disp_char` equal to bits [7:0] of the written word.
- R8: A write to the display data word while the display flag is zero produces no pulse and leaves `disp_char` unchanged.
- R9: After a pulse, the display flag stays zero until `disp_ready` is seen high, and is set again on that edge.
- R10: Writes to the keyboard status, keyboard data and display status words have no effect on any flag, stored character or display output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| mem_rdata | input | 16 | Read data from memory |
| bus_rdata | output | 16 | Read data returned to the processor |
| dev_sel | output | 1 | Read data comes from a device register |
| key_strobe | input | 1 | A key code is present on `key_char` |
| key_char | input | 8 | Key code |
| disp_ready | input | 1 | Display has taken the last character |
| disp_valid | output | 1 | One-cycle character pulse to the display |
| disp_char | output | 8 | Character for the display |

## Verification
The properties assume that the bus inputs carry known values at every clock edge once reset is released. They also assume that `disp_ready` is a level that the display may hold high for any length of time. The bench drives every input on the falling edge and holds it through the next rising edge. It keeps `disp_ready` low while it checks that the display stays busy, and raises it only when it checks the return of the ready flag. Key strobes are single-cycle pulses issued both while the keyboard flag is clear and while it is set.

// File: rtl/con_pkg.sv
package con_pkg;

    localparam int DATA_W = 16;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    typedef enum logic [1:0] {
        DSP_IDLE,
        DSP_SEND,
        DSP_WAIT
    } disp_state_e;

    function automatic logic [DATA_W-1:0] status_word(input logic flag);
        return {flag, {(DATA_W-1){1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] char_word(input logic [CHAR_W-1:0] c);
        return {{(DATA_W-CHAR_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/con_addr_decode.sv
module con_addr_decode
    import con_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op
);
    localparam int OFS_W = 3;

    logic in_window;

    always_comb begin
        in_window = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]) && !addr[0];
        op.sel = SEL_NONE;
        if (in_window) begin
            case (addr[OFS_W-1:1])
                2'd0:    op.sel = SEL_KSTAT;
                2'd1:    op.sel = SEL_KDATA;
                2'd2:    op.sel = SEL_DSTAT;
                default: op.sel = SEL_DDATA;
            endcase
        end
        op.rd = valid && !we && in_window;
        op.wr = valid && we && in_window;
    end
endmodule

// File: rtl/con_kbd_port.sv
module con_kbd_port
    import con_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              data_read,
    output logic              kbd_rdy,
    output logic [CHAR_W-1:0] kbd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            kbd_rdy  <= 1'b0;
            kbd_data <= '0;
        end else if (!kbd_rdy) begin
            if (key_strobe) begin
                kbd_rdy  <= 1'b1;
                kbd_data <= key_char;
            end
        end else if (data_read) begin
            kbd_rdy <= 1'b0;
        end
    end
endmodule

// File: rtl/con_disp_port.sv
module con_disp_port
    import con_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_write,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              disp_ready,
    output logic              disp_rdy,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char
);
    disp_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= DSP_IDLE;
            disp_char <= '0;
        end else begin
            case (state)
                DSP_IDLE: if (data_write) begin
                    state     <= DSP_SEND;
                    disp_char <= wr_char;
                end
                DSP_SEND: state <= DSP_WAIT;
                DSP_WAIT: if (disp_ready) state <= DSP_IDLE;
                default:  state <= DSP_IDLE;
            endcase
        end
    end

    assign disp_rdy   = (state == DSP_IDLE);
    assign disp_valid = (state == DSP_SEND);
endmodule

// File: rtl/console_io_ctrl.sv
module console_io_ctrl
    import con_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dev_sel,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              disp_ready,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char
);
    bus_op_t           op;
    logic              kbd_rdy;
    logic [CHAR_W-1:0] kbd_data;
    logic              disp_rdy;
    logic              kdata_read;
    logic              ddata_write;

    con_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_dec (
        .valid (bus_valid),
        .we    (bus_we),
        .addr  (bus_addr),
        .op    (op)
    );

    assign kdata_read  = op.rd && (op.sel == SEL_KDATA);
    assign ddata_write = op.wr && (op.sel == SEL_DDATA);

    con_kbd_port i_kbd (
        .clk        (clk),
        .rst        (rst),
        .key_strobe (key_strobe),
        .key_char   (key_char),
        .data_read  (kdata_read),
        .kbd_rdy    (kbd_rdy),
        .kbd_data   (kbd_data)
    );

    con_disp_port i_disp (
        .clk        (clk),
        .rst        (rst),
        .data_write (ddata_write),
        .wr_char    (bus_wdata[CHAR_W-1:0]),
        .disp_ready (disp_ready),
        .disp_rdy   (disp_rdy),
        .disp_valid (disp_valid),
        .disp_char  (disp_char)
    );

    assign dev_sel = op.rd;

    always_comb begin
        bus_rdata = mem_rdata;
        if (op.rd) begin
            case (op.sel)
                SEL_KSTAT: bus_rdata = status_word(kbd_rdy);
                SEL_KDATA: bus_rdata = char_word(kbd_data);
                SEL_DSTAT: bus_rdata = status_word(disp_rdy);
                SEL_DDATA: bus_rdata = char_word(disp_char);
                default:   bus_rdata = mem_rdata;
            endcase
        end
    end
endmodule

// File: rtl/con_io_checker.sv
module con_io_checker
    import con_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              key_strobe,
    input logic [CHAR_W-1:0] key_char,
    input logic              kbd_rdy,
    input logic [CHAR_W-1:0] kbd_data,
    input logic              kdata_read,
    input logic              ddata_write,
    input logic              disp_rdy,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [DATA_W-1:0] bus_rdata
);
    AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!kbd_rdy && key_strobe) |=> (kbd_rdy && kbd_data == $past(key_char))); // R3

    AST_KDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        kdata_read |-> (bus_rdata[DATA_W-1:CHAR_W] == '0)); // R3

    AST_KEY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (kbd_rdy && !kdata_read) |=> (kbd_rdy && $stable(kbd_data))); // R4

    AST_KEY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (kbd_rdy && kdata_read) |=> !kbd_rdy); // R5

    AST_DISP_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !disp_valid); // R7

    AST_DISP_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (disp_rdy && ddata_write) |=> (disp_valid && !disp_rdy)); // R7

    AST_DISP_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        (!disp_rdy && ddata_write) |=> !disp_valid); // R8

    AST_DISP_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!disp_rdy && !disp_ready) |=> !disp_rdy); // R9
endmodule

bind console_io_ctrl con_io_checker i_con_io_checker (
    .clk         (clk),
    .rst         (rst),
    .key_strobe  (key_strobe),
    .key_char    (key_char),
    .kbd_rdy     (kbd_rdy),
    .kbd_data    (kbd_data),
    .kdata_read  (kdata_read),
    .ddata_write (ddata_write),
    .disp_rdy    (disp_rdy),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .bus_rdata   (bus_rdata)
);

// File: tb/test_console_io_ctrl.sv
module test_console_io_ctrl;
    localparam logic [15:0] A_KSTAT = 16'hFE00;
    localparam logic [15:0] A_KDATA = 16'hFE02;
    localparam logic [15:0] A_DSTAT = 16'hFE04;
    localparam logic [15:0] A_DDATA = 16'hFE06;
    localparam logic [15:0] MEM_WORD = 16'h1234;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] mem_rdata = MEM_WORD;
    logic [15:0] bus_rdata;
    logic        dev_sel;
    logic        key_strobe = 1'b0;
    logic [7:0]  key_char = '0;
    logic        disp_ready = 1'b0;
    logic        disp_valid;
    logic [7:0]  disp_char;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    console_io_ctrl i_console_io_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .mem_rdata  (mem_rdata),
        .bus_rdata  (bus_rdata),
        .dev_sel    (dev_sel),
        .key_strobe (key_strobe),
        .key_char   (key_char),
        .disp_ready (disp_ready),
        .disp_valid (disp_valid),
        .disp_char  (disp_char)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] addr, output logic [15:0] data, output logic sel);
        bus_valid = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = addr;
        #1;
        data = bus_rdata;
        sel  = dev_sel;
        tick();
        bus_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [15:0] addr, input logic [15:0] data);
        bus_valid = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = addr;
        bus_wdata = data;
        tick();
        bus_valid = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic press(input logic [7:0] c);
        key_strobe = 1'b1;
        key_char   = c;
        tick();
        key_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        logic s;
        chk("R1 disp_valid", {15'b0, disp_valid}, 16'h0);
        chk("R1 disp_char", {8'h0, disp_char}, 16'h0);
        bus_read(A_KSTAT, d, s); chk("R1 kbd status", d, 16'h0000);
        bus_read(A_KDATA, d, s); chk("R1 kbd data", d, 16'h0000);
        bus_read(A_DSTAT, d, s); chk("R1 disp status", d, 16'h8000);
    endtask

    task automatic t_decode();
        logic [15:0] d;
        logic s;
        bus_read(16'h1000, d, s);
        chk("R2 mem data", d, MEM_WORD); chk("R2 dev_sel low", {15'b0, s}, 16'h0);
        bus_read(16'hFE08, d, s);
        chk("R2 above window", d, MEM_WORD); chk("R2 dev_sel FE08", {15'b0, s}, 16'h0);
        bus_read(16'hFE01, d, s);
        chk("R2 odd address", d, MEM_WORD);
        bus_read(A_DSTAT, d, s);
        chk("R2 dev_sel high", {15'b0, s}, 16'h1);
        bus_addr = A_DSTAT;
        #1;
        chk("R2 valid low passes memory", bus_rdata, MEM_WORD);
        chk("R2 valid low dev_sel", {15'b0, dev_sel}, 16'h0);
        tick();
    endtask

    task automatic t_keyboard();
        logic [15:0] d;
        logic s;
        press(8'h61);
        bus_read(A_KSTAT, d, s); chk("R3 flag set", d, 16'h8000);
        press(8'h62);
        bus_read(A_KSTAT, d, s); chk("R5 status read keeps flag", d, 16'h8000);
        bus_read(A_KDATA, d, s); chk("R4 second key dropped / R3 data", d, 16'h0061);
        bus_read(A_KSTAT, d, s); chk("R5 flag cleared", d, 16'h0000);
        press(8'hFA);
        bus_read(A_KDATA, d, s); chk("R5 next key accepted, R3 upper zero", d, 16'h00FA);
    endtask

    task automatic t_display();
        logic [15:0] d;
        logic s;
        bus_write(A_DDATA, 16'hAB41);
        chk("R7 pulse high", {15'b0, disp_valid}, 16'h1);
        chk("R7 char low byte", {8'h0, disp_char}, 16'h0041);
        bus_read(A_DSTAT, d, s); chk("R6 status busy", d, 16'h0000);
        chk("R7 pulse one cycle", {15'b0, disp_valid}, 16'h0);
        bus_write(A_DDATA, 16'h0055);
        chk("R8 no pulse when busy", {15'b0, disp_valid}, 16'h0);
        chk("R8 char unchanged", {8'h0, disp_char}, 16'h0041);
        tick();
        bus_read(A_DSTAT, d, s); chk("R9 busy until ready", d, 16'h0000);
        disp_ready = 1'b1;
        tick();
        disp_ready = 1'b0;
        bus_read(A_DSTAT, d, s); chk("R9 R6 ready again", d, 16'h8000);
        bus_write(A_DDATA, 16'h007E);
        chk("R7 second pulse", {15'b0, disp_valid}, 16'h1);
        chk("R7 second char", {8'h0, disp_char}, 16'h007E);
        tick();
        disp_ready = 1'b1;
        tick();
        disp_ready = 1'b0;
    endtask

    task automatic t_ignored_writes();
        logic [15:0] d;
        logic s;
        bus_write(A_KSTAT, 16'hFFFF);
        chk("R10 no pulse KSTAT", {15'b0, disp_valid}, 16'h0);
        bus_write(A_KDATA, 16'h00AA);
        bus_write(A_DSTAT, 16'h0000);
        chk("R10 no pulse DSTAT", {15'b0, disp_valid}, 16'h0);
        bus_read(A_KSTAT, d, s); chk("R10 kbd flag", d, 16'h0000);
        bus_read(A_KDATA, d, s); chk("R10 kbd data", d, 16'h00FA);
        bus_read(A_DSTAT, d, s); chk("R10 disp flag", d, 16'h8000);
        chk("R10 disp char", {8'h0, disp_char}, 16'h007E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_keyboard();
        t_display();
        t_ignored_writes();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule